// File: doc/BRIEF.md
# Virtualizable Interrupt-Flag Status Register

This block keeps the 64-bit flags register used by legacy-mode code and decides whether external interrupts are unmasked. The decision depends on the execution mode. In native mode only the processor-level interrupt enable counts. In legacy mode the register's interrupt flag (IF) can also take part, and a virtualization control word decides whether it does.

The control word has two bits. A gating bit makes the IF bit part of the unmask decision. An intercept bit makes every legacy change of IF (through flag-clear, flag-set or pop-flags) raise a one-cycle notification pulse. When both bits are 0, legacy software can toggle IF freely and nothing else happens.

Interrupt-return and task-switch operations would rewrite the nested-task (NT) bit. These are always intercepted: the register keeps its value and a separate pulse is raised. Decode, privilege checks and trap delivery belong to neighbouring logic.

Top module: `vflag_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `flags_o` reads 0x0000_0000_0000_0002, and `irq_enable_o`, `if_trap_o` and `nt_trap_o` are 0.
- R2: In legacy mode (`legacy_mode_i`=1), `irq_enable_o` becomes `proc_irq_en_i & (~virt_gate_i | IF)` one clock after the inputs are presented. IF is bit 9 of the register, and a write accepted at the same edge counts as the new value.
- R3: In native mode (`legacy_mode_i`=0), `irq_enable_o` becomes `proc_irq_en_i` one clock later, whatever the register holds. All write strobes are ignored: `flags_o` is unchanged and no pulse is raised.
- R4: In legacy mode, `op_clr_i` sets IF (bit 9) to 0 and `op_set_i` sets IF to 1 at the next edge, leaving every other bit unchanged. At most one strobe is high in a cycle.
- R5: In legacy mode, `op_pop_i` loads the following bits from `op_data_i`: CF 0, PF 2, AF 4, ZF 6, SF 7, TF 8, IF 9, DF 10, OF 11, IOPL 13:12, RF 16, VM 17, AC 18, VIF 19, VIP 20 and ID 21. Bit 1 reads 1. Bits 3, 5, 15 and 63:22 read 0. NT (bit 14) keeps its value.
- R6: When `virt_icpt_i`=1 and a legacy clear, set or pop changes IF, `if_trap_o` is 1 for exactly the one cycle after the write edge. A write that leaves IF unchanged raises no pulse.
- R7: With `virt_gate_i`=0 and `virt_icpt_i`=0, legacy writes still update IF, `irq_enable_o` follows `proc_irq_en_i` alone, and `if_trap_o` stays 0.
- R8: In legacy mode, `op_iret_i` or `op_task_i` leaves the whole register unchanged and raises `nt_trap_o` for one cycle, regardless of `virt_icpt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_irq_en_i | input | 1 | Processor-level interrupt enable |
| virt_gate_i | input | 1 | Virtualization: IF takes part in masking |
| virt_icpt_i | input | 1 | Virtualization: notify on IF changes |
| legacy_mode_i | input | 1 | 1 = legacy instruction mode, 0 = native |
| op_clr_i | input | 1 | Flag-clear strobe |
| op_set_i | input | 1 | Flag-set strobe |
| op_pop_i | input | 1 | Pop-flags strobe |
| op_iret_i | input | 1 | Interrupt-return strobe |
| op_task_i | input | 1 | Task-switch strobe |
| op_data_i | input | 64 | New flags value for pop, return and task switch |
| flags_o | output | 64 | Flags register as software reads it |
| irq_enable_o | output | 1 | Registered external-interrupt unmask |
| if_trap_o | output | 1 | One-cycle IF-change intercept pulse |
| nt_trap_o | output | 1 | One-cycle NT-write intercept pulse |

## Verification
The bench sweeps every combination of processor enable, gating bit, intercept bit and mode. Each combination is tried from both starting IF values against each operation: none, clear, set, a pop with IF 0, a pop with IF 1, return and task switch. The prior-IF axis separates real IF changes from writes of the same value, which is what decides whether a trap fires. The mode and gating axes separate the three unmask rules. Pops of all-ones and all-zeros patterns show that the fixed and reserved bits hold, and the cycle after each operation shows that every pulse lasts one cycle.

// File: rtl/vflag_pkg.sv
`timescale 1ns/1ps
package vflag_pkg;
    parameter int FLAG_W = 64;
    localparam int USED_W = 22;

    localparam int B_CF  = 0;
    localparam int B_ONE = 1;
    localparam int B_PF  = 2;
    localparam int B_AF  = 4;
    localparam int B_ZF  = 6;
    localparam int B_SF  = 7;
    localparam int B_TF  = 8;
    localparam int B_IF  = 9;
    localparam int B_DF  = 10;
    localparam int B_OF  = 11;
    localparam int B_PL0 = 12;
    localparam int B_PL1 = 13;
    localparam int B_NT  = 14;
    localparam int B_RF  = 16;
    localparam int B_VM  = 17;
    localparam int B_AC  = 18;
    localparam int B_VIF = 19;
    localparam int B_VIP = 20;
    localparam int B_ID  = 21;

    localparam logic [FLAG_W-1:0] RESET_VAL = FLAG_W'(1) << B_ONE;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CLR  = 3'd1,
        OP_SET  = 3'd2,
        OP_POP  = 3'd3,
        OP_IRET = 3'd4,
        OP_TASK = 3'd5
    } flag_op_e;

    typedef struct packed {
        logic              accept;
        logic              if_touch;
        logic              nt_touch;
        logic [FLAG_W-1:0] value;
    } flag_upd_t;

    // Bits that a pop may load from its data word.
    function automatic logic [FLAG_W-1:0] writable_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[B_CF] = 1'b1;  m[B_PF] = 1'b1;  m[B_AF] = 1'b1;  m[B_ZF] = 1'b1;
        m[B_SF] = 1'b1;  m[B_TF] = 1'b1;  m[B_IF] = 1'b1;  m[B_DF] = 1'b1;
        m[B_OF] = 1'b1;  m[B_PL0] = 1'b1; m[B_PL1] = 1'b1;
        m[B_RF] = 1'b1;  m[B_VM] = 1'b1;  m[B_AC] = 1'b1;  m[B_VIF] = 1'b1;
        m[B_VIP] = 1'b1; m[B_ID] = 1'b1;
        return m;
    endfunction

    function automatic logic [FLAG_W-1:0] clean_pop(input logic [FLAG_W-1:0] wd,
                                                    input logic nt_keep);
        logic [FLAG_W-1:0] r;
        r = wd & writable_mask();
        r[B_ONE] = 1'b1;
        r[B_NT]  = nt_keep;
        return r;
    endfunction
endpackage

// File: rtl/vflag_decode.sv
`timescale 1ns/1ps
module vflag_decode
    import vflag_pkg::*;
(
    input  logic     clr_i,
    input  logic     set_i,
    input  logic     pop_i,
    input  logic     iret_i,
    input  logic     task_i,
    output flag_op_e op_o
);
    always_comb begin
        if (task_i)      op_o = OP_TASK;
        else if (iret_i) op_o = OP_IRET;
        else if (pop_i)  op_o = OP_POP;
        else if (set_i)  op_o = OP_SET;
        else if (clr_i)  op_o = OP_CLR;
        else             op_o = OP_NONE;
    end
endmodule

// File: rtl/vflag_store.sv
`timescale 1ns/1ps
module vflag_store
    import vflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_i,
    input  flag_op_e          op_i,
    input  logic [FLAG_W-1:0] data_i,
    output flag_upd_t         upd_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] flags_q;

    always_comb begin
        upd_o.accept   = 1'b0;
        upd_o.if_touch = 1'b0;
        upd_o.nt_touch = 1'b0;
        upd_o.value    = flags_q;
        if (legacy_i) begin
            case (op_i)
                OP_CLR: begin
                    upd_o.accept      = 1'b1;
                    upd_o.if_touch    = 1'b1;
                    upd_o.value[B_IF] = 1'b0;
                end
                OP_SET: begin
                    upd_o.accept      = 1'b1;
                    upd_o.if_touch    = 1'b1;
                    upd_o.value[B_IF] = 1'b1;
                end
                OP_POP: begin
                    upd_o.accept   = 1'b1;
                    upd_o.if_touch = 1'b1;
                    upd_o.value    = clean_pop(data_i, flags_q[B_NT]);
                end
                OP_IRET, OP_TASK: upd_o.nt_touch = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               flags_q <= RESET_VAL;
        else if (upd_o.accept) flags_q <= upd_o.value;
    end

    assign flags_o = flags_q;

    assert_native_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !legacy_i |=> $stable(flags_q));
    assert_nt_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (legacy_i && (op_i == OP_IRET || op_i == OP_TASK)) |=> $stable(flags_q));
    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (legacy_i && op_i == OP_CLR) |=> !flags_q[B_IF]);
endmodule

// File: rtl/vflag_trap.sv
`timescale 1ns/1ps
module vflag_trap
    import vflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      icpt_i,
    input  flag_upd_t upd_i,
    input  logic      if_cur_i,
    output logic      if_trap_o,
    output logic      nt_trap_o
);
    logic if_flip;
    assign if_flip = upd_i.accept && upd_i.if_touch && (upd_i.value[B_IF] != if_cur_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            if_trap_o <= 1'b0;
            nt_trap_o <= 1'b0;
        end else begin
            if_trap_o <= icpt_i && if_flip;
            nt_trap_o <= upd_i.nt_touch;
        end
    end

    assert_if_trap_needs_icpt_R6: assert property (@(posedge clk) disable iff (rst)
        if_trap_o |-> $past(icpt_i));
    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !icpt_i |=> !if_trap_o);
endmodule

// File: rtl/vflag_irq.sv
`timescale 1ns/1ps
module vflag_irq (
    input  logic clk,
    input  logic rst,
    input  logic pie_i,
    input  logic gate_i,
    input  logic legacy_i,
    input  logic if_next_i,
    output logic irq_o
);
    logic unmask_d;
    assign unmask_d = pie_i && (!legacy_i || !gate_i || if_next_i);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= unmask_d;
    end

    assert_irq_needs_pie_R2: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(pie_i));
    assert_native_follows_pie_R3: assert property (@(posedge clk) disable iff (rst)
        (!legacy_i && pie_i) |=> irq_o);
    assert_ungated_follows_pie_R7: assert property (@(posedge clk) disable iff (rst)
        (legacy_i && !gate_i && pie_i) |=> irq_o);
endmodule

// File: rtl/vflag_unit.sv
`timescale 1ns/1ps
module vflag_unit
    import vflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_irq_en_i,
    input  logic              virt_gate_i,
    input  logic              virt_icpt_i,
    input  logic              legacy_mode_i,
    input  logic              op_clr_i,
    input  logic              op_set_i,
    input  logic              op_pop_i,
    input  logic              op_iret_i,
    input  logic              op_task_i,
    input  logic [FLAG_W-1:0] op_data_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_enable_o,
    output logic              if_trap_o,
    output logic              nt_trap_o
);
    flag_op_e  op;
    flag_upd_t upd;

    vflag_decode u_decode (
        .clr_i (op_clr_i),
        .set_i (op_set_i),
        .pop_i (op_pop_i),
        .iret_i(op_iret_i),
        .task_i(op_task_i),
        .op_o  (op)
    );

    vflag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .legacy_i(legacy_mode_i),
        .op_i    (op),
        .data_i  (op_data_i),
        .upd_o   (upd),
        .flags_o (flags_o)
    );

    vflag_trap u_trap (
        .clk      (clk),
        .rst      (rst),
        .icpt_i   (virt_icpt_i),
        .upd_i    (upd),
        .if_cur_i (flags_o[B_IF]),
        .if_trap_o(if_trap_o),
        .nt_trap_o(nt_trap_o)
    );

    vflag_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .pie_i    (proc_irq_en_i),
        .gate_i   (virt_gate_i),
        .legacy_i (legacy_mode_i),
        .if_next_i(upd.value[B_IF]),
        .irq_o    (irq_enable_o)
    );

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_clr_i, op_set_i, op_pop_i, op_iret_i, op_task_i}));
    assert_if_trap_is_change_R6: assert property (@(posedge clk) disable iff (rst)
        if_trap_o |-> (flags_o[B_IF] != $past(flags_o[B_IF])));
    assert_nt_trap_cause_R8: assert property (@(posedge clk) disable iff (rst)
        nt_trap_o |-> $past(legacy_mode_i && (op_iret_i || op_task_i)));
    assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (rst)
        flags_o[B_ONE] && !flags_o[3] && !flags_o[5] && !flags_o[15]
        && (flags_o[FLAG_W-1:USED_W] == '0));
endmodule

// File: tb/test_vflag_unit.sv
`timescale 1ns/1ps
module test_vflag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pie = 1'b0, gate = 1'b0, icpt = 1'b0, legacy = 1'b0;
    logic        s_clr = 1'b0, s_set = 1'b0, s_pop = 1'b0, s_iret = 1'b0, s_task = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] flags;
    logic        irq, if_trap, nt_trap;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    vflag_unit i_vflag_unit (
        .clk(clk), .rst(rst),
        .proc_irq_en_i(pie), .virt_gate_i(gate), .virt_icpt_i(icpt),
        .legacy_mode_i(legacy),
        .op_clr_i(s_clr), .op_set_i(s_set), .op_pop_i(s_pop),
        .op_iret_i(s_iret), .op_task_i(s_task), .op_data_i(wdata),
        .flags_o(flags), .irq_enable_o(irq), .if_trap_o(if_trap), .nt_trap_o(nt_trap)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic strobes_off();
        s_clr = 0; s_set = 0; s_pop = 0; s_iret = 0; s_task = 0;
    endtask

    function automatic logic [63:0] pop_model(input logic [63:0] d, input logic [63:0] cur);
        return (d & 64'h0000_0000_003F_3FD5) | (cur & 64'h4000) | 64'h2;
    endfunction

    logic [63:0] exp_flags;

    initial begin
        exp_flags = 64'h2;
        repeat (3) @(posedge clk);
        #2;
        // R1: state while reset is held
        chk(flags == 64'h2, "R1 flags", flags, 64'h2);
        chk(irq == 0 && if_trap == 0 && nt_trap == 0, "R1 outputs",
            {61'd0, irq, if_trap, nt_trap}, 64'd0);
        rst = 0;
        tick();
        chk(flags == 64'h2, "R1 flags after release", flags, 64'h2);
        chk(irq == 0, "R1 irq after release", {63'd0, irq}, 64'd0);

        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int prior = 0; prior < 2; prior++) begin
                for (int op = 0; op < 7; op++) begin
                    logic        e_pie, e_gate, e_icpt, e_leg, old_if, new_if;
                    logic        acc, e_ift, e_ntt, e_irq;
                    logic [63:0] e_new, d;
                    string       irq_tag, flg_tag, trp_tag;
                    // prime IF to the prior value in legacy mode, intercept off
                    legacy = 1; icpt = 0; gate = 0; pie = 0;
                    s_clr = (prior == 0); s_set = (prior == 1);
                    tick();
                    strobes_off();
                    exp_flags[9] = prior[0];
                    chk(flags == exp_flags, "R4 prime", flags, exp_flags);

                    e_pie = cfg[0]; e_gate = cfg[1]; e_icpt = cfg[2]; e_leg = cfg[3];
                    pie = e_pie; gate = e_gate; icpt = e_icpt; legacy = e_leg;
                    d = 64'hA5C3_F00F_9E37_79B9 ^ (64'(cfg) * 64'h0101_0101_0101_0101)
                        ^ (64'(prior) << 40);
                    if (op == 3) d[9] = 1'b0;
                    if (op == 4) d[9] = 1'b1;
                    wdata = d;
                    case (op)
                        1: s_clr = 1;
                        2: s_set = 1;
                        3, 4: s_pop = 1;
                        5: s_iret = 1;
                        6: s_task = 1;
                        default: ;
                    endcase
                    old_if = exp_flags[9];
                    e_new  = exp_flags;
                    acc    = e_leg && (op >= 1 && op <= 4);
                    if (acc) begin
                        if (op == 1) e_new[9] = 1'b0;
                        else if (op == 2) e_new[9] = 1'b1;
                        else e_new = pop_model(d, exp_flags);
                    end
                    new_if = e_new[9];
                    e_ift  = acc && e_icpt && (new_if != old_if);
                    e_ntt  = e_leg && (op >= 5);
                    e_irq  = e_pie && (!e_leg || !e_gate || new_if);
                    irq_tag = !e_leg ? "R3" : (!e_gate && !e_icpt) ? "R7" : "R2";
                    flg_tag = !e_leg ? "R3" : (op >= 5) ? "R8" : (op >= 3) ? "R5" : "R4";
                    trp_tag = (e_leg && !e_gate && !e_icpt) ? "R7" : "R6";
                    tick();
                    strobes_off();
                    exp_flags = e_new;
                    chk(flags == exp_flags, {flg_tag, " flags"}, flags, exp_flags);
                    chk(irq == e_irq, {irq_tag, " irq"}, {63'd0, irq}, {63'd0, e_irq});
                    chk(if_trap == e_ift, {trp_tag, " if_trap"}, {63'd0, if_trap}, {63'd0, e_ift});
                    chk(nt_trap == e_ntt, "R8 nt_trap", {63'd0, nt_trap}, {63'd0, e_ntt});
                    tick();
                    chk(if_trap == 0, "R6 pulse width", {63'd0, if_trap}, 64'd0);
                    chk(nt_trap == 0, "R8 pulse width", {63'd0, nt_trap}, 64'd0);
                    chk(irq == e_irq, {irq_tag, " irq hold"}, {63'd0, irq}, {63'd0, e_irq});
                    chk(flags == exp_flags, {flg_tag, " flags hold"}, flags, exp_flags);
                end
            end
        end

        // R5: fixed and reserved bits under extreme pop patterns
        legacy = 1; icpt = 0; gate = 0; pie = 0;
        wdata = '1; s_pop = 1;
        tick();
        strobes_off();
        chk(flags == 64'h0000_0000_003F_3FD7, "R5 pop all ones", flags, 64'h3F3FD7);
        wdata = '0; s_pop = 1;
        tick();
        strobes_off();
        chk(flags == 64'h2, "R5 pop all zeros", flags, 64'h2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule